// File: doc/BRIEF.md
# Oscillator Suspend and Wake Controller

This block sits on the free-running internal oscillator clock and decides when the system clock derived from it is gated off. Software suspends the oscillator by writing a one to the suspend bit of a control register. While suspended, the block holds its clock-enable output low, which stops the processor and the peripherals fed from the gated clock. It watches a set of wake sources and restores the clock when any one of them fires. Restoring the clock involves no reset and no jump, so execution simply carries on after the suspending write.

There are two kinds of wake source. The first is a match event on any of three ports. The second is a comparator, but a comparator only counts while it is enabled and its output sits low. Each wake line is resynchronised to the oscillator clock by a two-flop chain. Waking happens whether or not the event is also taken as an interrupt.

The PLL cannot be the system clock during suspend. Software therefore has to move off the PLL before suspending. If software writes the suspend bit while the PLL is still selected, the write is refused and an error flag is raised. After every wake, a PLL-invalid flag tells software to reinitialise the PLL before it selects it again. Software clears that flag by writing an acknowledge bit. The block also holds an 8-bit calibration register for the oscillator period. Its reset value is loaded from a trim input.

Top module: `osc_suspend_ctl`

## Requirements
- R1: During and after reset: `suspended` = 0, `clk_en` = 1, `pll_invalid` = 0, the error flag = 0, and `cal_value` equals `trim_init`.
- R2: A write to the control register (address 0xB2) with data bit 5 set, while `pll_selected` = 0 and the block is not suspended, makes `suspended` = 1 and `clk_en` = 0 from the next clock edge.
- R3: A suspend write made while `pll_selected` = 1 is ignored, and `suspended` stays 0. The write sets the error flag, which reads back as control bit 6. Writing a one to control bit 6 clears the flag, but a refused suspend write in the same cycle takes priority.
- R4: A port-match event (`port_match`) that is held while suspended clears `suspended` and raises `clk_en` on the third clock edge after the event is first seen: two edges of synchronisation, then one edge to update.
- R5: A comparator wakes the block only when its `cmp_en` bit is 1 and its `cmp_out` bit is 0. An enabled comparator with a high output does not wake it, and neither does a disabled comparator with a low output.
- R6: Each wake sets `pll_invalid`, which reads back as control bit 1. The flag stays set until a control write with data bit 0 set. A wake in the same cycle as that write takes priority.
- R7: Wake events that occur while the block is not suspended have no effect on `suspended`, `clk_en` or `pll_invalid`.
- R8: The calibration register at address 0xBF is readable and writable, and its value drives `cal_value`.
- R9: `rd_data` is combinational. At the control address it returns {0, error, suspended, 0, 0, 0, pll_invalid, 0}, from bit 7 down to bit 0. At the calibration address it returns the calibration value. At any other address it returns 0. Control bits other than 0, 5 and 6 have no effect when written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running internal oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trim_init | input | 8 | Factory trim value loaded into calibration at reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Register read data |
| pll_selected | input | 1 | System clock currently sourced from the PLL |
| port_match | input | 3 | Port-match event lines |
| cmp_en | input | 2 | Comparator enable bits |
| cmp_out | input | 2 | Comparator output levels |
| clk_en | output | 1 | Enable for the gated system clock |
| suspended | output | 1 | Oscillator suspended status |
| pll_invalid | output | 1 | PLL must be reinitialised before reselection |
| cal_value | output | 8 | Current calibration value |

## Verification
The hardest case to reach is a wake event that races the suspend itself. This happens when an event is already travelling through the synchroniser at the moment the suspend write lands, or when it fires in the same cycle as a PLL acknowledge. The outcome then depends on exactly which edge each register updates on. The random phase drives sparse port-match pulses and low-probability comparator drops together with frequent control writes, so these overlaps happen many times. Directed sequences pin down the three-edge wake latency and the comparator enable and level combinations.

// File: rtl/osc_suspend_ctl.sv
module osc_suspend_ctl #(
  parameter logic [7:0] CTRL_ADDR = 8'hB2,
  parameter logic [7:0] CAL_ADDR  = 8'hBF,
  parameter int SUSP_BIT = 5,
  parameter int ERR_BIT  = 6,
  parameter int ACK_BIT  = 0,
  parameter int INV_BIT  = 1,
  parameter int N_PORT   = 3,
  parameter int N_CMP    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        trim_init,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [7:0]        rd_addr,
  output logic [7:0]        rd_data,
  input  logic              pll_selected,
  input  logic [N_PORT-1:0] port_match,
  input  logic [N_CMP-1:0]  cmp_en,
  input  logic [N_CMP-1:0]  cmp_out,
  output logic              clk_en,
  output logic              suspended,
  output logic              pll_invalid,
  output logic [7:0]        cal_value
);
  localparam int NW = N_PORT + N_CMP;

  logic [NW-1:0] wake_raw, sync1, sync2;
  logic susp_q, err_q, inv_q;
  logic [7:0] cal_q;

  assign wake_raw = {cmp_en & ~cmp_out, port_match};

  wire ctrl_wr  = wr_en && (wr_addr == CTRL_ADDR);
  wire susp_req = ctrl_wr && wr_data[SUSP_BIT] && !susp_q;
  wire accept   = susp_req && !pll_selected;
  wire refuse   = susp_req && pll_selected;
  wire wake_hit = susp_q && (|sync2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= wake_raw;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      susp_q <= 1'b0;
      err_q  <= 1'b0;
      inv_q  <= 1'b0;
      cal_q  <= trim_init;
    end else begin
      if (accept)        susp_q <= 1'b1;
      else if (wake_hit) susp_q <= 1'b0;

      if (refuse)                          err_q <= 1'b1;
      else if (ctrl_wr && wr_data[ERR_BIT]) err_q <= 1'b0;

      if (wake_hit)                         inv_q <= 1'b1;
      else if (ctrl_wr && wr_data[ACK_BIT]) inv_q <= 1'b0;

      if (wr_en && wr_addr == CAL_ADDR) cal_q <= wr_data;
    end
  end

  assign suspended   = susp_q;
  assign clk_en      = ~susp_q;
  assign pll_invalid = inv_q;
  assign cal_value   = cal_q;

  always_comb begin
    rd_data = '0;
    if (rd_addr == CTRL_ADDR) begin
      rd_data[SUSP_BIT] = susp_q;
      rd_data[ERR_BIT]  = err_q;
      rd_data[INV_BIT]  = inv_q;
    end else if (rd_addr == CAL_ADDR) begin
      rd_data = cal_q;
    end
  end

  // R2
  susp_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == CTRL_ADDR && wr_data[SUSP_BIT] && !pll_selected && !suspended)
    |=> (suspended && !clk_en));

  // R3
  pll_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == CTRL_ADDR && wr_data[SUSP_BIT] && pll_selected && !suspended)
    |=> (!suspended && rd_data_err_ok));

  // R4
  wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && (|sync2)) |=> (!suspended && clk_en && pll_invalid));

  // R6
  inv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_invalid && !(wr_en && wr_addr == CTRL_ADDR && wr_data[ACK_BIT])) |=> pll_invalid);

  // R7
  inv_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_invalid) |-> $fell(suspended));

  wire rd_data_err_ok = err_q;
endmodule

// File: tb/tb_osc_suspend_ctl.sv
`timescale 1ns/1ps
module tb_osc_suspend_ctl;
  localparam logic [7:0] CTRL = 8'hB2;
  localparam logic [7:0] CAL  = 8'hBF;

  logic clk = 0, rst_n = 0;
  logic [7:0] trim_init = 8'h5A;
  logic wr_en = 0;
  logic [7:0] wr_addr = 0, wr_data = 0, rd_addr = CTRL, rd_data;
  logic pll_selected = 0;
  logic [2:0] port_match = 0;
  logic [1:0] cmp_en = 0, cmp_out = 2'b11;
  logic clk_en, suspended, pll_invalid;
  logic [7:0] cal_value;

  osc_suspend_ctl dut (.clk(clk), .rst_n(rst_n), .trim_init(trim_init),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .pll_selected(pll_selected), .port_match(port_match),
    .cmp_en(cmp_en), .cmp_out(cmp_out), .clk_en(clk_en), .suspended(suspended),
    .pll_invalid(pll_invalid), .cal_value(cal_value));

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic m_susp, m_err, m_inv;
  logic [7:0] m_cal;
  logic [4:0] m_s1, m_s2;

  function automatic logic [7:0] exp_rd(logic [7:0] a);
    if (a == CTRL) return {1'b0, m_err, m_susp, 3'b0, m_inv, 1'b0};
    if (a == CAL) return m_cal;
    return 8'h00;
  endfunction

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic cw, req, wake;
    cw   = wr_en && wr_addr == CTRL;
    req  = cw && wr_data[5] && !m_susp;
    wake = m_susp && (|m_s2);
    if (!rst_n) begin
      m_susp = 0; m_err = 0; m_inv = 0; m_cal = trim_init; m_s1 = 0; m_s2 = 0;
    end else begin
      if (req && !pll_selected) m_susp = 1;
      else if (wake) m_susp = 0;
      if (req && pll_selected) m_err = 1;
      else if (cw && wr_data[6]) m_err = 0;
      if (wake) m_inv = 1;
      else if (cw && wr_data[0]) m_inv = 0;
      if (wr_en && wr_addr == CAL) m_cal = wr_data;
      m_s2 = m_s1;
      m_s1 = {cmp_en & ~cmp_out, port_match};
    end
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(tag, "suspended", {7'b0, suspended}, {7'b0, m_susp});
    chk(tag, "clk_en", {7'b0, clk_en}, {7'b0, ~m_susp});
    chk(tag, "pll_invalid", {7'b0, pll_invalid}, {7'b0, m_inv});
    chk(tag, "cal_value", cal_value, m_cal);
    chk(tag, "rd_data", rd_data, exp_rd(rd_addr));
  endtask

  task automatic wr(string tag, logic [7:0] a, logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    cyc(tag);
    wr_en = 0;
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  initial begin
    void'($urandom(32'h1234_5678));
    idle("R1", 3);
    rst_n = 1;
    idle("R1", 2);
    // R2 and R4: suspend, then port-match wake with fixed latency
    wr("R2", CTRL, 8'h20);
    idle("R2", 2);
    port_match = 3'b010;
    cyc("R4"); cyc("R4");
    chk("R4", "clk_en before 3rd edge", {7'b0, clk_en}, 8'h00);
    cyc("R4");
    chk("R4", "clk_en at 3rd edge", {7'b0, clk_en}, 8'h01);
    port_match = 0;
    idle("R6", 3);
    // R6: acknowledge clears flag
    wr("R6", CTRL, 8'h01);
    chk("R6", "pll_invalid cleared", {7'b0, pll_invalid}, 8'h00);
    // R3: refused suspend while on PLL
    pll_selected = 1;
    wr("R3", CTRL, 8'h20);
    chk("R3", "err bit", rd_data & 8'h40, 8'h40);
    chk("R3", "not suspended", {7'b0, suspended}, 8'h00);
    pll_selected = 0;
    wr("R3", CTRL, 8'h40);
    chk("R3", "err cleared", rd_data & 8'h40, 8'h00);
    // R7: events while running do nothing
    port_match = 3'b111; cmp_en = 2'b11; cmp_out = 2'b00;
    idle("R7", 5);
    chk("R7", "no pll_invalid", {7'b0, pll_invalid}, 8'h00);
    port_match = 0; cmp_out = 2'b11;
    idle("R7", 3);
    // R5: comparator qualification
    wr("R5", CTRL, 8'h20);
    cmp_en = 2'b01; cmp_out = 2'b01;
    idle("R5", 2);
    cmp_en = 2'b00; cmp_out = 2'b00;
    idle("R5", 5);
    chk("R5", "still suspended", {7'b0, suspended}, 8'h01);
    cmp_en = 2'b10;
    idle("R5", 4);
    chk("R5", "woke on cmp1 low", {7'b0, suspended}, 8'h00);
    cmp_en = 0; cmp_out = 2'b11;
    idle("R5", 3);
    // R8 and R9: calibration and readback
    wr("R8", CAL, 8'hC3);
    rd_addr = CAL; cyc("R8");
    chk("R8", "cal readback", rd_data, 8'hC3);
    rd_addr = 8'h10; cyc("R9");
    wr("R9", CTRL, 8'h9E);
    rd_addr = CTRL; cyc("R9");
    // Random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      wr_en = (r < 20);
      case ($urandom_range(0, 3))
        0, 1: wr_addr = CTRL;
        2: wr_addr = CAL;
        default: wr_addr = 8'($urandom);
      endcase
      wr_data = 8'($urandom);
      rd_addr = ($urandom_range(0, 3) == 0) ? CAL : CTRL;
      pll_selected = ($urandom_range(0, 3) == 0);
      for (int b = 0; b < 3; b++) port_match[b] = ($urandom_range(0, 39) == 0);
      cmp_en = 2'($urandom);
      for (int b = 0; b < 2; b++) cmp_out[b] = ($urandom_range(0, 19) != 0);
      cyc("R9");
    end
    wr_en = 0;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule